// File: doc/BRIEF.md
# Lookahead-Reserved Operand Mesh Router

This block is the router at one node of a two-dimensional grid of ALUs. It moves a single 64-bit operand from the ALU that produced it to the ALU that will consume it, hop by hop, never copying it to every node. The route comes only from a destination node identifier that the producing instruction carries. The low field of the identifier gives the column and the high field gives the row.

Each link has two planes. A narrow header plane carries the destination identifier and runs one cycle ahead. At each output, a round-robin arbiter grants the header and writes a reservation record of the input that won. In the following cycle the payload plane uses that record to take the operand from the winning input. The payload plane does no routing of its own. A header that loses arbitration, or that faces a full output, is simply not accepted. It waits at its source and competes again in the next cycle, and its payload is not sent until the header is accepted.

The header plane uses valid/ready. A source raises valid with a stable destination and holds both until ready is high at a clock edge. The payload plane has no ready. The source presents the payload with its valid for exactly the one cycle that follows the header handshake. Towards a neighbour, the router holds its output header until that neighbour returns ready. It presents the payload in the cycle after that handshake. The eject side toward the local ALU never applies back-pressure.

Top module: `opmesh_router`

## Requirements
- R1: Routing is dimension-ordered. Let x be destination bits [2:0] and y be bits [5:3]. If x is above this node's column the output is east (lane 1); if x is below it, west (lane 3). If x matches and y is below this node's row the output is north (lane 0); if y is above it, south (lane 2). If both match the operand is ejected. Input lanes 0..3 use the same direction numbering, and input lane 4 is the local ALU inject.
- R2: A header accepted at a clock edge appears on the output that R1 selects in the next cycle, with the same destination.
- R3: The payload leaves an output in the cycle right after that output's header handshake. It carries the data that the winning input presented in the cycle after the grant. In any other cycle the output payload valid is low.
- R4: An operand addressed to this node appears on the eject port two cycles after its header handshake, which is one cycle after its payload was presented.
- R5: An injected header addressed to this node is accepted at once. It reserves nothing, and no output, including eject, ever carries its payload.
- R6: While an output header is valid and its ready is low, the header stays valid and its destination stays unchanged.
- R7: Each output grants at most one header per cycle, and every accepted operand that is not self-addressed is delivered exactly once.
- R8: When two or more headers keep contending for one free output, the winner changes every cycle. The priority pointer moves to just past the last winner.
- R9: During reset every output header valid, output payload valid and eject valid is low.
- R10: Every reservation finds its payload valid on the granted input in the cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_hdr_valid | input | 5 | Header valid per input lane (0 N, 1 E, 2 S, 3 W, 4 inject) |
| in_hdr_ready | output | 5 | Header accepted per input lane |
| in_hdr_dst | input | 5x6 | Destination identifier per input lane |
| in_dat_valid | input | 5 | Payload valid per input lane |
| in_dat | input | 5x64 | Payload per input lane |
| out_hdr_valid | output | 4 | Header valid per neighbour output |
| out_hdr_ready | input | 4 | Neighbour accepts the header |
| out_hdr_dst | output | 4x6 | Destination identifier per neighbour output |
| out_dat_valid | output | 4 | Payload valid per neighbour output |
| out_dat | output | 4x64 | Payload per neighbour output |
| ej_valid | output | 1 | Operand delivered to the local ALU |
| ej_data | output | 64 | Delivered operand |

## Verification
Each result is due at a fixed offset from a handshake. An output header is due one cycle after its input handshake, a payload one cycle after its output header handshake, and an eject two cycles after the header handshake. The bench samples every handshake at the falling edge. It stores each expectation tagged with the cycle in which it is due, and checks that exact cycle. It also checks that no payload valid appears in any cycle where none is due. Arbitration order is never predicted from random traffic. Exact data, single delivery and alternation under a directed two-way contest cover it instead.

// File: rtl/opmesh_pkg.sv
package opmesh_pkg;
  localparam int NPORT = 5;
  localparam int NDIR  = 4;
  localparam int P_N   = 0;
  localparam int P_E   = 1;
  localparam int P_S   = 2;
  localparam int P_W   = 3;
  localparam int P_L   = 4;
endpackage

// File: rtl/opmesh_route.sv
module opmesh_route
  import opmesh_pkg::*;
#(
  parameter int X_W  = 3,
  parameter int Y_W  = 3,
  parameter int MY_X = 0,
  parameter int MY_Y = 0
) (
  input  logic [X_W+Y_W-1:0] dst,
  output logic [NPORT-1:0]   dir
);
  localparam logic [X_W-1:0] HX = X_W'(MY_X);
  localparam logic [Y_W-1:0] HY = Y_W'(MY_Y);

  logic [X_W-1:0] dx;
  logic [Y_W-1:0] dy;

  assign dx = dst[X_W-1:0];
  assign dy = dst[X_W+Y_W-1:X_W];

  // R1: column first, then row, then eject
  always_comb begin
    dir = '0;
    if (dx > HX)      dir[P_E] = 1'b1;
    else if (dx < HX) dir[P_W] = 1'b1;
    else if (dy < HY) dir[P_N] = 1'b1;
    else if (dy > HY) dir[P_S] = 1'b1;
    else              dir[P_L] = 1'b1;
  end
endmodule

// File: rtl/opmesh_rr_arb.sv
module opmesh_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         en,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr;
  logic [PW-1:0] win;
  logic          found;

  always_comb begin
    int idx;
    gnt   = '0;
    win   = ptr;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      idx = int'(ptr) + i;
      if (idx >= N) idx = idx - N;
      if (!found && en && req[idx]) begin
        gnt[idx] = 1'b1;
        win      = PW'(idx);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (found) ptr <= (win == PW'(N - 1)) ? '0 : win + 1'b1;
  end

  a_r7_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r7_grant_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  a_r8_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && en && $past(en) && req == $past(req) &&
     $countones(req) > 1 && $past(|gnt)) |-> gnt != $past(gnt));
endmodule

// File: rtl/opmesh_outport.sv
module opmesh_outport #(
  parameter int NP     = 5,
  parameter int DATA_W = 64,
  parameter int ID_W   = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NP-1:0]             gnt,
  input  logic [NP-1:0][ID_W-1:0]   in_dst,
  input  logic [NP-1:0]             in_dat_v,
  input  logic [NP-1:0][DATA_W-1:0] in_dat,
  input  logic                      down_ready,
  output logic                      avail,
  output logic                      hdr_v,
  output logic [ID_W-1:0]           hdr_dst,
  output logic                      dat_v,
  output logic [DATA_W-1:0]         dat
);
  logic              res_v;
  logic [NP-1:0]     res_src;
  logic [ID_W-1:0]   g_dst;
  logic              sel_v;
  logic [DATA_W-1:0] sel_d;
  logic              fire;

  always_comb begin
    g_dst = '0;
    sel_v = 1'b0;
    sel_d = '0;
    for (int i = 0; i < NP; i++) begin
      if (gnt[i])     g_dst = g_dst | in_dst[i];
      if (res_src[i]) begin
        sel_v = sel_v | in_dat_v[i];
        sel_d = sel_d | in_dat[i];
      end
    end
  end

  assign fire  = hdr_v && down_ready;
  assign avail = !hdr_v || down_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_v   <= 1'b0;
      hdr_dst <= '0;
      res_v   <= 1'b0;
      res_src <= '0;
      dat_v   <= 1'b0;
      dat     <= '0;
    end else begin
      if (|gnt) begin
        hdr_v   <= 1'b1;
        hdr_dst <= g_dst;
      end else if (fire) begin
        hdr_v <= 1'b0;
      end
      res_v   <= |gnt;
      res_src <= gnt;
      dat_v   <= fire;
      if (res_v) dat <= sel_d;
    end
  end

  a_r6_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_v && !down_ready) |=> (hdr_v && $stable(hdr_dst)));

  a_r2_hdr_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |=> (hdr_v && hdr_dst == $past(g_dst)));

  a_r7_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> avail);

  a_r10_payload_present: assert property (@(posedge clk) disable iff (!rst_n)
    res_v |-> sel_v);
endmodule

// File: rtl/opmesh_router.sv
module opmesh_router
  import opmesh_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int X_W    = 3,
  parameter int Y_W    = 3,
  parameter int MY_X   = 3,
  parameter int MY_Y   = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NPORT-1:0]                 in_hdr_valid,
  output logic [NPORT-1:0]                 in_hdr_ready,
  input  logic [NPORT-1:0][X_W+Y_W-1:0]    in_hdr_dst,
  input  logic [NPORT-1:0]                 in_dat_valid,
  input  logic [NPORT-1:0][DATA_W-1:0]     in_dat,
  output logic [NDIR-1:0]                  out_hdr_valid,
  input  logic [NDIR-1:0]                  out_hdr_ready,
  output logic [NDIR-1:0][X_W+Y_W-1:0]     out_hdr_dst,
  output logic [NDIR-1:0]                  out_dat_valid,
  output logic [NDIR-1:0][DATA_W-1:0]      out_dat,
  output logic                             ej_valid,
  output logic [DATA_W-1:0]                ej_data
);
  localparam int ID_W = X_W + Y_W;
  localparam logic [ID_W-1:0] SELF_ID = {Y_W'(MY_Y), X_W'(MY_X)};

  logic [NPORT-1:0][NPORT-1:0]  dir_m;   // [input][direction]
  logic [NPORT-1:0][NPORT-1:0]  req_m;   // [output][input]
  logic [NPORT-1:0][NPORT-1:0]  gnt_m;   // [output][input]
  logic [NPORT-1:0]             avail;
  logic [NPORT-1:0]             hv;
  logic [NPORT-1:0]             dv;
  logic [NPORT-1:0]             dn_rdy;
  logic [NPORT-1:0][ID_W-1:0]   hd;
  logic [NPORT-1:0][DATA_W-1:0] dd;
  logic                         self_inj;

  for (genvar p = 0; p < NPORT; p++) begin : g_rt
    opmesh_route #(.X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_rt (
      .dst (in_hdr_dst[p]),
      .dir (dir_m[p])
    );
  end

  // R5: an inject addressed here stays in the ALU's own bypass
  assign self_inj = dir_m[P_L][P_L];

  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int p = 0; p < NPORT; p++)
        req_m[o][p] = in_hdr_valid[p] && dir_m[p][o] && !(p == P_L && o == P_L);
  end

  always_comb begin
    in_hdr_ready = '0;
    for (int p = 0; p < NPORT; p++)
      for (int o = 0; o < NPORT; o++)
        in_hdr_ready[p] = in_hdr_ready[p] | gnt_m[o][p];
    in_hdr_ready[P_L] = in_hdr_ready[P_L] | (in_hdr_valid[P_L] && self_inj);
  end

  assign dn_rdy = {1'b1, out_hdr_ready};

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    opmesh_rr_arb #(.N(NPORT)) u_arb (
      .clk (clk),
      .rst_n (rst_n),
      .req (req_m[o]),
      .en  (avail[o]),
      .gnt (gnt_m[o])
    );
    opmesh_outport #(.NP(NPORT), .DATA_W(DATA_W), .ID_W(ID_W)) u_op (
      .clk        (clk),
      .rst_n      (rst_n),
      .gnt        (gnt_m[o]),
      .in_dst     (in_hdr_dst),
      .in_dat_v   (in_dat_valid),
      .in_dat     (in_dat),
      .down_ready (dn_rdy[o]),
      .avail      (avail[o]),
      .hdr_v      (hv[o]),
      .hdr_dst    (hd[o]),
      .dat_v      (dv[o]),
      .dat        (dd[o])
    );
  end

  assign out_hdr_valid = hv[NDIR-1:0];
  assign out_hdr_dst   = hd[NDIR-1:0];
  assign out_dat_valid = dv[NDIR-1:0];
  assign out_dat       = dd[NDIR-1:0];
  assign ej_valid      = dv[P_L];
  assign ej_data       = dd[P_L];

  a_r5_self_inject: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hdr_valid[P_L] && self_inj) |-> (in_hdr_ready[P_L] && !(gnt_m[P_L][P_L])));

  a_r4_eject_self: assert property (@(posedge clk) disable iff (!rst_n)
    hv[P_L] |-> hd[P_L] == SELF_ID);
endmodule

// File: tb/opmesh_router_bench.sv
module opmesh_router_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0]        in_hdr_valid, in_hdr_ready, in_dat_valid;
  logic [4:0][5:0]   in_hdr_dst;
  logic [4:0][63:0]  in_dat;
  logic [3:0]        out_hdr_valid, out_hdr_ready, out_dat_valid;
  logic [3:0][5:0]   out_hdr_dst;
  logic [3:0][63:0]  out_dat;
  logic              ej_valid;
  logic [63:0]       ej_data;

  always #10 clk = ~clk;

  opmesh_router u_opmesh_router (
    .clk(clk), .rst_n(rst_n),
    .in_hdr_valid(in_hdr_valid), .in_hdr_ready(in_hdr_ready), .in_hdr_dst(in_hdr_dst),
    .in_dat_valid(in_dat_valid), .in_dat(in_dat),
    .out_hdr_valid(out_hdr_valid), .out_hdr_ready(out_hdr_ready), .out_hdr_dst(out_hdr_dst),
    .out_dat_valid(out_dat_valid), .out_dat(out_dat),
    .ej_valid(ej_valid), .ej_data(ej_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int mode = 1;          // 0 random, 1 idle, 2 contest
  int rr_n = 0;
  logic [1:0] rr_prev;
  logic [63:0] hdr_pay [5];
  bit pay_next [5];
  bit exp_hdr_v [4];
  logic [5:0] exp_hdr_d [4];
  bit hold_v [4];
  logic [5:0] hold_d [4];
  bit exp_dat_v [4];
  logic [63:0] exp_dat [4];
  logic [63:0] held_pay [4];
  bit ej_s1_v, exp_ej_v;
  logic [63:0] ej_s1, exp_ej;
  int unsigned next_id = 1;
  longint sent_n = 0, recv_n = 0;
  longint unsigned sent_sum = 0, recv_sum = 0;

  // node sits at column 3, row 4
  function automatic int exp_dir(logic [5:0] d);
    if (d[2:0] > 3'd3) return 1;
    if (d[2:0] < 3'd3) return 3;
    if (d[5:3] < 3'd4) return 0;
    if (d[5:3] > 3'd4) return 2;
    return 4;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic put_hdr(int p, logic [5:0] d);
    in_hdr_valid[p] = 1'b1;
    in_hdr_dst[p]   = d;
    hdr_pay[p]      = {next_id, 26'b0, d};
    next_id++;
  endtask

  task automatic observe();
    int cnt [5];
    for (int o = 0; o < 4; o++) begin
      if (exp_hdr_v[o])
        chk(out_hdr_valid[o] && out_hdr_dst[o] == exp_hdr_d[o], "R1 R2",
            {57'b0, out_hdr_valid[o], out_hdr_dst[o]}, {57'b1, exp_hdr_d[o]});
      if (hold_v[o])
        chk(out_hdr_valid[o] && out_hdr_dst[o] == hold_d[o], "R6",
            {57'b0, out_hdr_valid[o], out_hdr_dst[o]}, {57'b1, hold_d[o]});
      if (exp_dat_v[o]) chk(out_dat_valid[o] && out_dat[o] == exp_dat[o], "R3", out_dat[o], exp_dat[o]);
      else chk(!out_dat_valid[o], "R3", {63'b0, out_dat_valid[o]}, 64'd0);
      if (out_dat_valid[o]) begin recv_n++; recv_sum += out_dat[o][63:32]; end
    end
    if (exp_ej_v) chk(ej_valid && ej_data == exp_ej, "R4", ej_data, exp_ej);
    else chk(!ej_valid, "R4 R5", {63'b0, ej_valid}, 64'd0);
    if (ej_valid) begin recv_n++; recv_sum += ej_data[63:32]; end

    for (int o = 0; o < 4; o++) begin
      exp_dat_v[o] = out_hdr_valid[o] && out_hdr_ready[o];
      exp_dat[o]   = held_pay[o];
      hold_v[o]    = out_hdr_valid[o] && !out_hdr_ready[o];
      hold_d[o]    = out_hdr_dst[o];
      exp_hdr_v[o] = 1'b0;
    end
    exp_ej_v = ej_s1_v;
    exp_ej   = ej_s1;
    ej_s1_v  = 1'b0;
    for (int o = 0; o < 5; o++) cnt[o] = 0;
    for (int p = 0; p < 5; p++) begin
      pay_next[p] = 1'b0;
      if (in_hdr_valid[p]) begin
        logic [5:0] d;
        int o;
        d = in_hdr_dst[p];
        o = exp_dir(d);
        if (p == 4 && o == 4) chk(in_hdr_ready[4], "R5", {63'b0, in_hdr_ready[4]}, 64'd1);
        if (in_hdr_ready[p]) begin
          pay_next[p] = 1'b1;
          if (!(p == 4 && o == 4)) begin
            cnt[o]++;
            sent_n++;
            sent_sum += hdr_pay[p][63:32];
            if (o < 4) begin
              exp_hdr_v[o] = 1'b1;
              exp_hdr_d[o] = d;
              held_pay[o]  = hdr_pay[p];
            end else begin
              ej_s1_v = 1'b1;
              ej_s1   = hdr_pay[p];
            end
          end
        end
      end
    end
    for (int o = 0; o < 5; o++)
      if (cnt[o] > 1) chk(1'b0, "R7", 64'(cnt[o]), 64'd1);
    if (mode == 2) begin
      logic [1:0] r;
      r = {in_hdr_ready[2], in_hdr_ready[0]};
      rr_n++;
      if (rr_n > 2) begin
        chk(r == 2'b01 || r == 2'b10, "R8", {62'b0, r}, 64'd1);
        chk(r != rr_prev, "R8", {62'b0, r}, {62'b0, ~rr_prev});
      end
      rr_prev = r;
    end
  endtask

  task automatic drive();
    for (int p = 0; p < 5; p++) begin
      in_dat_valid[p] = pay_next[p];
      in_dat[p]       = pay_next[p] ? hdr_pay[p] : 64'd0;
      if (pay_next[p] || !in_hdr_valid[p]) begin
        in_hdr_valid[p] = 1'b0;
        if (mode == 0 && ($urandom % 100) < 55) put_hdr(p, 6'($urandom));
        else if (mode == 2 && (p == 0 || p == 2)) put_hdr(p, {3'd4, 3'd5});
      end
    end
    for (int o = 0; o < 4; o++)
      out_hdr_ready[o] = (mode == 0) ? (($urandom % 4) != 0) : 1'b1;
  endtask

  task automatic cycle();
    @(negedge clk);
    observe();
    @(posedge clk);
    #1;
    drive();
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd4242);
    in_hdr_valid = '0; in_hdr_dst = '0; in_dat_valid = '0; in_dat = '0;
    out_hdr_ready = '0;
    for (int p = 0; p < 5; p++) begin pay_next[p] = 0; hdr_pay[p] = '0; end
    for (int o = 0; o < 4; o++) begin
      exp_hdr_v[o] = 0; hold_v[o] = 0; exp_dat_v[o] = 0; held_pay[o] = '0;
    end
    ej_s1_v = 0; exp_ej_v = 0;
    // R9: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_hdr_valid == 4'b0 && out_dat_valid == 4'b0 && !ej_valid, "R9",
          {55'b0, ej_valid, out_dat_valid, out_hdr_valid}, 64'd0);
    end
    @(posedge clk); #1; rst_n = 1'b1;
    cycle();

    // R1: one directed header per direction, sent from various lanes
    put_hdr(4, {3'd2, 3'd3}); cycle(); cycle(); cycle();
    put_hdr(4, {3'd4, 3'd6}); cycle(); cycle(); cycle();
    put_hdr(3, {3'd7, 3'd3}); cycle(); cycle(); cycle();
    put_hdr(1, {3'd4, 3'd0}); cycle(); cycle(); cycle();
    put_hdr(0, {3'd4, 3'd3}); cycle(); cycle(); cycle(); cycle();

    // R5: self-addressed inject leaves nothing on any output
    put_hdr(4, {3'd4, 3'd3});
    for (int i = 0; i < 4; i++) begin
      cycle();
      chk(out_hdr_valid == 4'b0 && !ej_valid, "R5", {59'b0, ej_valid, out_hdr_valid}, 64'd0);
    end

    // R8: two lanes contend for east
    mode = 2;
    for (int i = 0; i < 12; i++) cycle();
    mode = 1;
    for (int i = 0; i < 10; i++) cycle();

    // random traffic with back-pressure
    mode = 0;
    for (int i = 0; i < 4000; i++) cycle();
    mode = 1;
    for (int i = 0; i < 40; i++) cycle();

    // R7: every accepted operand delivered exactly once
    chk(sent_n == recv_n, "R7", 64'(recv_n), 64'(sent_n));
    chk(sent_sum == recv_sum, "R7", recv_sum, sent_sum);
    chk(sent_n > 1000, "R7", 64'(sent_n), 64'd1000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule